// File: doc/BRIEF.md
# CRC Feedback-Term Table Builder

This block computes, at run time, the 256-entry feedback-term table that a byte-at-a-time CRC engine uses. The user supplies the generator polynomial in reflected form: the highest-order term goes in bit 0, and the leading x^32 (or x^16) term is implied and left out. The user also selects a 16-bit or 32-bit width and pulses a start input. The block then walks through every byte value. For each one it runs eight right-shifting shift/conditional-xor steps and stores the 32-bit result in an internal RAM.

The builder spends one clock on each shift step, so a full build takes 2048 clocks. While the build runs, a busy flag is high. When the last entry is written, a done strobe fires for one cycle. A synchronous read port lets the neighbouring CRC engine look up any entry. Only one table is held at a time. A new build overwrites the previous one.

Typical reflected words are 0xEDB88320 for the 32-bit Ethernet-style polynomial, 0x8408 for x^16+x^12+x^5+1 and 0xA001 for x^16+x^15+x^2+1.

Top module: `crc_table_gen`

## Requirements
- R1: After reset, `busy` and `donePulse` are 0.
- R2: A `startPulse` sampled high while idle makes `busy` high from the next cycle on. `busy` stays high for exactly 2048 cycles. `donePulse` is high for exactly one cycle, in the first cycle in which `busy` is low again.
- R3: Entry b (0..255) equals the result of eight steps that start from the register value b zero-extended to 32 bits. Each step is: if bit 0 is 1, shift right one place with zero fill and xor with the polynomial; otherwise only shift right. As a consequence, entry 0 is 0 and entry 128 equals the polynomial.
- R4: With `wideSel`=0 (16-bit mode), bits 31:16 of `polyIn` are treated as zero. Every entry then has bits 31:16 equal to 0. With `wideSel`=1, all 32 bits of the polynomial are used.
- R5: A `startPulse` that arrives while `busy` is high is ignored. The build neither restarts nor changes its timing.
- R6: `rdData` presents the entry at the `rdAddr` sampled on a clock edge, valid after that edge (one cycle of read latency).
- R7: `polyIn` and `wideSel` are captured on the accepted start. Later changes to either input have no effect on the table being built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a table build when idle |
| polyIn | input | 32 | Reflected polynomial, top term implied |
| wideSel | input | 1 | 1 = 32-bit polynomial, 0 = 16-bit polynomial |
| rdAddr | input | 8 | Table index to look up |
| busy | output | 1 | Build in progress |
| donePulse | output | 1 | One-cycle strobe when the build completes |
| rdData | output | 32 | Table entry for the previously sampled address |

## Verification
`busy` is due one edge after an accepted start and falls 2048 edges later, on the same edge where `donePulse` rises. A behavioural model in the bench advances on every rising edge, and both control outputs are compared against it at every falling edge. Read data is due one edge after `rdAddr` is set, so each lookup drives the address at a falling edge and compares `rdData` at the next falling edge. Starts issued during a build, and polynomial changes made during a build, are shown to be ignored by the unchanged done timing and by the contents read back afterwards.

// File: rtl/crc_tbl_pkg.sv
package crc_tbl_pkg;
  // strobes from sequencing control into the shift/store datapath
  typedef struct packed {
    logic load;   // accepted start: capture polynomial and width
    logic first;  // first step of an entry: seed register with byte value
    logic step;   // perform one shift/xor step this cycle
    logic write;  // last step of an entry: store its result
  } ctlStrobe_t;
endpackage

// File: rtl/crc_tbl_ctrl.sv
module crc_tbl_ctrl
  import crc_tbl_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int STEPS   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startPulse,
  output ctlStrobe_t                 strobe,
  output logic [$clog2(ENTRIES)-1:0] byteIdx,
  output logic                       busy,
  output logic                       donePulse
);
  localparam int ADDR_W = $clog2(ENTRIES);
  localparam int STEP_W = $clog2(STEPS);
  localparam int CNT_W  = ADDR_W + STEP_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRIES * STEPS - 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  logic [CNT_W-1:0]  cnt;
  logic [STEP_W-1:0] stepIdx;
  logic              atLast;

  assign stepIdx = cnt[STEP_W-1:0];
  assign byteIdx = cnt[CNT_W-1:STEP_W];
  assign atLast  = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      donePulse <= 1'b0;
      cnt       <= '0;
    end else begin
      donePulse <= 1'b0;
      if (!busy) begin
        if (startPulse) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else if (atLast) begin
        busy      <= 1'b0;
        donePulse <= 1'b1;
        cnt       <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load  = !busy && startPulse;
    strobe.step  = busy;
    strobe.first = busy && (stepIdx == '0);
    strobe.write = busy && (stepIdx == LAST_STEP);
  end

  // R2: accepted start raises busy on the next edge
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse) |=> busy);
  // R2: done only as busy falls
  p_done_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busy && $past(busy)));
  // R2: done lasts a single cycle
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  // R5: start while building does not rewind the sequence
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && !atLast) |=> (busy && cnt != '0));
endmodule

// File: rtl/crc_tbl_dp.sv
module crc_tbl_dp
  import crc_tbl_pkg::*;
#(
  parameter int ENTRIES  = 256,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 strobe,
  input  logic [$clog2(ENTRIES)-1:0] byteIdx,
  input  logic [DATA_W-1:0]          polyIn,
  input  logic                       wideSel,
  input  logic [$clog2(ENTRIES)-1:0] rdAddr,
  output logic [DATA_W-1:0]          rdData
);
  localparam int ADDR_W = $clog2(ENTRIES);

  logic [DATA_W-1:0] polyMask;
  logic [DATA_W-1:0] polyQ;
  logic              wideQ;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shiftIn;
  logic [DATA_W-1:0] stepVal;
  logic [DATA_W-1:0] tableMem [ENTRIES];

  // lanes above the narrow width follow the width select
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < NARROW_W) begin : g_low
      assign polyMask[i] = 1'b1;
    end else begin : g_high
      assign polyMask[i] = wideSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polyQ <= '0;
      wideQ <= 1'b0;
    end else if (strobe.load) begin
      polyQ <= polyIn & polyMask;
      wideQ <= wideSel;
    end
  end

  assign shiftIn = strobe.first ? {{(DATA_W-ADDR_W){1'b0}}, byteIdx} : shiftReg;
  assign stepVal = shiftIn[0] ? ((shiftIn >> 1) ^ polyQ) : (shiftIn >> 1);

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.step) shiftReg <= stepVal;
  end

  always_ff @(posedge clk) begin
    if (strobe.write) tableMem[byteIdx] <= stepVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else rdData <= tableMem[rdAddr];
  end

  // R4: narrow builds never store bits above the narrow width
  p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && !wideQ) |-> (stepVal[DATA_W-1:NARROW_W] == '0));
  // R3: byte value zero always yields a zero entry
  p_entry_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && byteIdx == '0) |-> (stepVal == '0));
  // R7: captured polynomial holds while entries are being stepped
  p_poly_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && $past(strobe.step)) |-> $stable(polyQ));
endmodule

// File: rtl/crc_table_gen.sv
module crc_table_gen
  import crc_tbl_pkg::*;
#(
  parameter int ENTRIES  = 256,
  parameter int STEPS    = 8,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startPulse,
  input  logic [DATA_W-1:0]          polyIn,
  input  logic                       wideSel,
  input  logic [$clog2(ENTRIES)-1:0] rdAddr,
  output logic                       busy,
  output logic                       donePulse,
  output logic [DATA_W-1:0]          rdData
);
  localparam int ADDR_W = $clog2(ENTRIES);

  ctlStrobe_t        strobe;
  logic [ADDR_W-1:0] byteIdx;

  crc_tbl_ctrl #(.ENTRIES(ENTRIES), .STEPS(STEPS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .strobe     (strobe),
    .byteIdx    (byteIdx),
    .busy       (busy),
    .donePulse  (donePulse)
  );

  crc_tbl_dp #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .byteIdx (byteIdx),
    .polyIn  (polyIn),
    .wideSel (wideSel),
    .rdAddr  (rdAddr),
    .rdData  (rdData)
  );

  // R1: control outputs quiet in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rstN) |-> (!busy && !donePulse));
endmodule

// File: tb/sim_crc_table_gen.sv
module sim_crc_table_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [31:0] polyIn = '0;
  logic        wideSel = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic        busy, donePulse;
  logic [31:0] rdData;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference state
  bit          mBusy = 0;
  bit          mDone = 0;
  int          mCnt = 0;
  logic [31:0] mPoly = '0;
  bit          mWide = 0;
  bit          modelOn = 0;

  always #5 clk = ~clk;

  crc_table_gen u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .polyIn(polyIn),
    .wideSel(wideSel), .rdAddr(rdAddr), .busy(busy), .donePulse(donePulse),
    .rdData(rdData)
  );

  function automatic logic [31:0] refEntry(int b, logic [31:0] p, bit w);
    logic [31:0] r = 32'(b);
    logic [31:0] q = w ? p : (p & 32'h0000FFFF);
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ q) : (r >> 1);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mCnt = 0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mCnt++;
        if (mCnt == 2048) begin mBusy = 0; mDone = 1; end
      end else if (startPulse) begin
        mBusy = 1; mCnt = 0; mPoly = polyIn; mWide = wideSel;
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn && !finished) begin
      chk("R2/R5 busy", 32'(busy), 32'(mBusy));
      chk("R2/R5 donePulse", 32'(donePulse), 32'(mDone));
    end
  end

  task automatic startBuild(logic [31:0] p, bit w);
    @(negedge clk);
    startPulse = 1'b1; polyIn = p; wideSel = w;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (mBusy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readChk(string req, int a, logic [31:0] exp);
    @(negedge clk);
    rdAddr = 8'(a);
    @(negedge clk);
    chk(req, rdData, exp);
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < 256; a++) readChk(req, a, refEntry(a, mPoly, mWide));
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 done after reset", 32'(donePulse), 32'd0);
    modelOn = 1;

    // 32-bit polynomial
    startBuild(32'hEDB88320, 1'b1);
    waitIdle();
    readChk("R3 entry1 32b", 1, 32'h77073096);
    readChk("R3 entry255 32b", 255, 32'h2D02EF8D);
    readChk("R3 entry128 equals poly", 128, 32'hEDB88320);
    readChk("R3 entry0 zero", 0, 32'h0);
    sweep("R3/R6 32b sweep");

    // 16-bit mode with junk in upper polynomial bits; mid-build disturbance
    startBuild(32'hFFFF8408, 1'b0);
    repeat (100) @(negedge clk);
    startPulse = 1'b1; polyIn = 32'h12345678; wideSel = 1'b1;  // R5, R7: ignored
    @(negedge clk);
    startPulse = 1'b0;
    repeat (500) @(negedge clk);
    polyIn = 32'hA001; wideSel = 1'b1;                          // R7: ignored
    waitIdle();
    readChk("R4 entry1 ccitt", 1, 32'h00001189);
    readChk("R4 entry128 masked poly", 128, 32'h00008408);
    readChk("R7 entry255 uses captured poly", 255, refEntry(255, 32'h8408, 1'b0));
    sweep("R4/R7 16b sweep");

    // second 16-bit polynomial; start held several cycles
    @(negedge clk);
    startPulse = 1'b1; polyIn = 32'h0000A001; wideSel = 1'b0;
    repeat (4) @(negedge clk);
    polyIn = 32'h0;
    startPulse = 1'b0;
    waitIdle();
    readChk("R3 entry1 crc16", 1, 32'h0000C0C1);
    readChk("R3 entry128 crc16", 128, 32'h0000A001);
    readChk("R6 back-to-back read", 2, refEntry(2, 32'hA001, 1'b0));
    sweep("R3 crc16 sweep");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule